// File: doc/BRIEF.md
# Single-Precision Compare Flag Unit

This block compares two IEEE-754 single-precision values and reports the result as three condition flags (carry, parity, zero) packed into one byte. Each compare is started by a one-cycle valid strobe and carries its own mode bit. In ordered mode, any NaN operand raises the invalid exception. In unordered mode, only a signaling NaN raises it.

Exceptions collect in a six-bit sticky status register. Software can clear that register or load it with a new value. Signed zeros, denormals and infinities are treated as ordinary numbers and ordered by sign and magnitude. The flag register and the status register are the only state.

The block is not built around a state machine. The result of each compare is one of four relations: greater (REL_GT), less (REL_LT), equal (REL_EQ) and unordered (REL_UN). One `unique case` maps the relation to the flag byte. The flag register and the status register are each written in their own process.

Top module: `fpcmp_flag_unit`

## Requirements
- R1: Right after reset, `flags_out` is 8'h00 and `stat_out` is 6'h00.
- R2: If the first operand is greater than the second, the compare clears all three flags, so `flags_out` = 8'h00.
- R3: If the first operand is less than the second, only carry (bit 0) is set, so `flags_out` = 8'h01.
- R4: If the operands are equal, only zero (bit 6) is set, so `flags_out` = 8'h40. Positive zero and negative zero count as equal.
- R5: An operand is a NaN when its exponent field [30:23] is all ones and its fraction [22:0] is nonzero. If either operand is a NaN, carry, parity (bit 2) and zero are all set, so `flags_out` = 8'h45. An infinity is not a NaN.
- R6: Values that are not NaN are ordered by sign and magnitude:
  - Any negative value is below any positive value.
  - Among negative values, the one with the larger magnitude is lower.
  - Denormals take part as ordinary values.
- R7: With `op_mode`=0 (unordered mode), the invalid bit (`stat_out[0]`) is set only when at least one operand is a signaling NaN. A signaling NaN is a NaN with bit 22 = 0. A quiet NaN (bit 22 = 1) leaves the status register unchanged.
- R8: With `op_mode`=1 (ordered mode), any NaN operand, quiet or signaling, sets `stat_out[0]`.
- R9: The status bits are invalid [0], denormal [1], divide-by-zero [2], overflow [3], underflow [4] and precision [5]. Each bit is sticky: once set, it stays set across later compares until the register is cleared or written. A pulse on `stat_wr` loads `stat_wdata` into all six bits.
- R10: A pulse on `stat_clr` zeroes the register, and it takes priority over `stat_wr` in the same cycle. An invalid raised by a compare in that same cycle is still ORed into the new value.
- R11: The flags and the status register update on the rising edge where `op_valid` is high. While `op_valid` is low, `flags_out` holds its value even when the operands change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Start-compare strobe |
| op_mode | input | 1 | 0 = unordered compare, 1 = ordered compare |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| stat_clr | input | 1 | Clear the sticky status register |
| stat_wr | input | 1 | Load the status register from `stat_wdata` |
| stat_wdata | input | 6 | Value to load into the status register |
| flags_out | output | 8 | Packed flags: carry bit 0, parity bit 2, zero bit 6 |
| stat_out | output | 6 | Sticky exception status |

## Verification
Both results have a latency of one cycle. The flag byte and the status bits show the outcome of a strobed compare, clear or write right after the rising edge that captured the inputs. The bench drives stimulus on the falling edge, waits for the next rising edge and samples 1 ns later, so each check sees exactly one update. The hold case changes the operands while the strobe is low, then samples after one more edge to confirm the flags did not move.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

    typedef enum logic [1:0] {
        REL_GT = 2'd0,
        REL_LT = 2'd1,
        REL_EQ = 2'd2,
        REL_UN = 2'd3
    } rel_e;

    typedef enum logic {
        CMP_UNORD = 1'b0,
        CMP_ORD   = 1'b1
    } cmp_mode_e;

    localparam int FLAG_W     = 8;
    localparam int FLG_CARRY  = 0;
    localparam int FLG_PARITY = 2;
    localparam int FLG_ZERO   = 6;

    localparam int STAT_W    = 6;
    localparam int STAT_INV  = 0;
    localparam int STAT_DEN  = 1;
    localparam int STAT_DZ   = 2;
    localparam int STAT_OVF  = 3;
    localparam int STAT_UNF  = 4;
    localparam int STAT_PREC = 5;

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] val,
    output logic                 is_nan,
    output logic                 is_snan,
    output logic                 is_zero
);
    localparam int W = 1 + EXP_W + MAN_W;

    logic [EXP_W-1:0] expf;
    logic [MAN_W-1:0] frac;

    assign expf = val[W-2:MAN_W];
    assign frac = val[MAN_W-1:0];

    always_comb begin
        is_nan  = (&expf) && (|frac);
        is_snan = is_nan && !frac[MAN_W-1];
        is_zero = ~|val[W-2:0];
    end
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
    import fpcmp_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] val_a,
    input  logic [EXP_W+MAN_W:0] val_b,
    input  logic                 a_nan,
    input  logic                 b_nan,
    input  logic                 a_zero,
    input  logic                 b_zero,
    output rel_e                 rel
);
    localparam int W = 1 + EXP_W + MAN_W;

    logic         sgn_a, sgn_b;
    logic [W-2:0] mag_a, mag_b;
    logic         mag_gt;

    assign sgn_a  = val_a[W-1];
    assign sgn_b  = val_b[W-1];
    assign mag_a  = val_a[W-2:0];
    assign mag_b  = val_b[W-2:0];
    assign mag_gt = (mag_a > mag_b);

    always_comb begin
        if (a_nan || b_nan) begin
            rel = REL_UN;
        end else if ((a_zero && b_zero) || (val_a == val_b)) begin
            rel = REL_EQ;
        end else if (sgn_a != sgn_b) begin
            rel = sgn_a ? REL_LT : REL_GT;
        end else if (!sgn_a) begin
            rel = mag_gt ? REL_GT : REL_LT;
        end else begin
            rel = mag_gt ? REL_LT : REL_GT;
        end
    end
endmodule

// File: rtl/fpcmp_status_reg.sv
module fpcmp_status_reg
    import fpcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr,
    input  logic [STAT_W-1:0] wdata,
    input  logic              set_inv,
    output logic [STAT_W-1:0] stat
);
    logic [STAT_W-1:0] base_v;
    logic [STAT_W-1:0] stat_d;

    always_comb begin
        if (clr) begin
            base_v = '0;
        end else if (wr) begin
            base_v = wdata;
        end else begin
            base_v = stat;
        end
        stat_d = base_v;
        stat_d[STAT_INV] = base_v[STAT_INV] | set_inv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat <= '0;
        end else begin
            stat <= stat_d;
        end
    end
endmodule

// File: rtl/fpcmp_flag_unit.sv
module fpcmp_flag_unit
    import fpcmp_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   op_valid,
    input  logic                   op_mode,
    input  logic [EXP_W+MAN_W:0]   opnd_a,
    input  logic [EXP_W+MAN_W:0]   opnd_b,
    input  logic                   stat_clr,
    input  logic                   stat_wr,
    input  logic [5:0]             stat_wdata,
    output logic [7:0]             flags_out,
    output logic [5:0]             stat_out
);
    localparam int W    = 1 + EXP_W + MAN_W;
    localparam int NOPD = 2;

    logic [W-1:0]    opnd [NOPD];
    logic [NOPD-1:0] nan_v, snan_v, zero_v;

    assign opnd[0] = opnd_a;
    assign opnd[1] = opnd_b;

    for (genvar gi = 0; gi < NOPD; gi++) begin : g_cls
        fpcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
            .val     (opnd[gi]),
            .is_nan  (nan_v[gi]),
            .is_snan (snan_v[gi]),
            .is_zero (zero_v[gi])
        );
    end

    rel_e rel;

    fpcmp_order #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_ord (
        .val_a  (opnd_a),
        .val_b  (opnd_b),
        .a_nan  (nan_v[0]),
        .b_nan  (nan_v[1]),
        .a_zero (zero_v[0]),
        .b_zero (zero_v[1]),
        .rel    (rel)
    );

    cmp_mode_e mode;
    logic      inv_hit;
    logic      set_inv;

    assign mode = cmp_mode_e'(op_mode);

    always_comb begin
        unique case (mode)
            CMP_ORD:   inv_hit = |nan_v;
            CMP_UNORD: inv_hit = |snan_v;
            default:   inv_hit = 1'b0;
        endcase
        set_inv = op_valid && inv_hit;
    end

    logic [FLAG_W-1:0] flag_d;
    logic [FLAG_W-1:0] flag_q;

    always_comb begin
        flag_d = '0;
        unique case (rel)
            REL_GT: flag_d = '0;
            REL_LT: flag_d[FLG_CARRY] = 1'b1;
            REL_EQ: flag_d[FLG_ZERO] = 1'b1;
            REL_UN: begin
                flag_d[FLG_CARRY]  = 1'b1;
                flag_d[FLG_PARITY] = 1'b1;
                flag_d[FLG_ZERO]   = 1'b1;
            end
            default: flag_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else if (op_valid) begin
            flag_q <= flag_d;
        end
    end

    assign flags_out = flag_q;

    fpcmp_status_reg u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (stat_clr),
        .wr      (stat_wr),
        .wdata   (stat_wdata),
        .set_inv (set_inv),
        .stat    (stat_out)
    );
endmodule

// File: rtl/fpcmp_flag_unit_chk.sv
module fpcmp_flag_unit_chk #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 op_valid,
    input logic                 op_mode,
    input logic [EXP_W+MAN_W:0] opnd_a,
    input logic [EXP_W+MAN_W:0] opnd_b,
    input logic                 stat_clr,
    input logic                 stat_wr,
    input logic [5:0]           stat_wdata,
    input logic [7:0]           flags_out,
    input logic [5:0]           stat_out
);
    localparam int W = 1 + EXP_W + MAN_W;

    logic a_nan, b_nan, a_snan, b_snan, any_nan, any_snan;
    assign a_nan    = (&opnd_a[W-2:MAN_W]) && (|opnd_a[MAN_W-1:0]);
    assign b_nan    = (&opnd_b[W-2:MAN_W]) && (|opnd_b[MAN_W-1:0]);
    assign a_snan   = a_nan && !opnd_a[MAN_W-1];
    assign b_snan   = b_nan && !opnd_b[MAN_W-1];
    assign any_nan  = a_nan || b_nan;
    assign any_snan = a_snan || b_snan;

    // R11
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(flags_out));

    // R2
    flags_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_out == 8'h00) || (flags_out == 8'h01) ||
        (flags_out == 8'h40) || (flags_out == 8'h45));

    // R5
    unord_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && any_nan) |=> (flags_out == 8'h45));

    // R8
    ord_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_mode && any_nan) |=> stat_out[0]);

    // R7
    quiet_noinv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_mode && !any_snan && !stat_wr && !stat_clr && !stat_out[0])
        |=> !stat_out[0]);

    // R9
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_clr && !stat_wr) |=> ((stat_out & $past(stat_out)) == $past(stat_out)));

    // R10
    clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !op_valid) |=> (stat_out == 6'h00));
endmodule

bind fpcmp_flag_unit fpcmp_flag_unit_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_mode    (op_mode),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .stat_clr   (stat_clr),
    .stat_wr    (stat_wr),
    .stat_wdata (stat_wdata),
    .flags_out  (flags_out),
    .stat_out   (stat_out)
);

// File: tb/sim_fpcmp_flag_unit.sv
`timescale 1ns/1ps
module sim_fpcmp_flag_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_mode = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        stat_clr = 1'b0;
    logic        stat_wr = 1'b0;
    logic [5:0]  stat_wdata = '0;
    logic [7:0]  flags_out;
    logic [5:0]  stat_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [31:0] F1000 = 32'h447A0000;
    localparam logic [31:0] F5    = 32'h40A00000;
    localparam logic [31:0] F3000 = 32'h453B8000;
    localparam logic [31:0] FP1   = 32'h3F800000;
    localparam logic [31:0] FN1   = 32'hBF800000;
    localparam logic [31:0] FN3K  = 32'hC53B8000;
    localparam logic [31:0] FN5   = 32'hC0A00000;
    localparam logic [31:0] PZERO = 32'h00000000;
    localparam logic [31:0] NZERO = 32'h80000000;
    localparam logic [31:0] QNAN  = 32'h7FC00000;
    localparam logic [31:0] SNAN  = 32'h7F800001;
    localparam logic [31:0] PINF  = 32'h7F800000;

    always #4 clk = ~clk;

    fpcmp_flag_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_mode(op_mode),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .stat_clr(stat_clr), .stat_wr(stat_wr),
        .stat_wdata(stat_wdata), .flags_out(flags_out), .stat_out(stat_out)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cmp(input logic md, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        op_valid = 1'b1; op_mode = md; opnd_a = a; opnd_b = b;
        @(posedge clk); #1;
        op_valid = 1'b0;
    endtask

    task automatic stat_op(input logic c, input logic w, input logic [5:0] d);
        @(negedge clk);
        stat_clr = c; stat_wr = w; stat_wdata = d;
        @(posedge clk); #1;
        stat_clr = 1'b0; stat_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 flags", flags_out, 8'h00);
        chk("R1 stat", {2'b0, stat_out}, 8'h00);
    endtask

    task automatic t_greater();
        cmp(1'b0, F1000, F5);   chk("R2 1000>5", flags_out, 8'h00);
        cmp(1'b1, PINF, F1000); chk("R5 inf not nan", flags_out, 8'h00);
        chk("R8 inf no invalid", {2'b0, stat_out}, 8'h00);
    endtask

    task automatic t_less();
        cmp(1'b0, F1000, F3000); chk("R3 1000<3000", flags_out, 8'h01);
    endtask

    task automatic t_equal();
        cmp(1'b0, F1000, F1000); chk("R4 equal", flags_out, 8'h40);
        cmp(1'b1, PZERO, NZERO); chk("R4 +0==-0", flags_out, 8'h40);
    endtask

    task automatic t_order();
        cmp(1'b0, FN1, FP1);         chk("R6 neg<pos", flags_out, 8'h01);
        cmp(1'b0, FN3K, FN5);        chk("R6 -3000<-5", flags_out, 8'h01);
        cmp(1'b0, FN5, FN3K);        chk("R6 -5>-3000", flags_out, 8'h00);
        cmp(1'b0, 32'h2, 32'h1);     chk("R6 denorm gt", flags_out, 8'h00);
        cmp(1'b0, 32'h80000001, PZERO); chk("R6 neg denorm lt", flags_out, 8'h01);
    endtask

    task automatic t_unord_mode();
        cmp(1'b0, F1000, QNAN);
        chk("R5 qnan flags", flags_out, 8'h45);
        chk("R7 qnan no invalid", {2'b0, stat_out}, 8'h00);
        cmp(1'b0, F1000, SNAN);
        chk("R5 snan flags", flags_out, 8'h45);
        chk("R7 snan invalid", {2'b0, stat_out}, 8'h01);
        cmp(1'b0, F5, F1000);
        chk("R9 sticky", {2'b0, stat_out}, 8'h01);
        chk("R3 after nan", flags_out, 8'h01);
    endtask

    task automatic t_clear();
        stat_op(1'b1, 1'b0, 6'h00);
        chk("R10 clear", {2'b0, stat_out}, 8'h00);
    endtask

    task automatic t_ord_mode();
        cmp(1'b1, QNAN, F1000);
        chk("R8 qnan invalid", {2'b0, stat_out}, 8'h01);
        stat_op(1'b1, 1'b0, 6'h00);
        cmp(1'b1, F1000, SNAN);
        chk("R8 snan invalid", {2'b0, stat_out}, 8'h01);
        stat_op(1'b1, 1'b0, 6'h00);
    endtask

    task automatic t_write();
        stat_op(1'b0, 1'b1, 6'h2A);
        chk("R9 write", {2'b0, stat_out}, 8'h2A);
        cmp(1'b0, SNAN, F5);
        chk("R9 invalid onto written", {2'b0, stat_out}, 8'h2B);
        cmp(1'b1, F5, F1000);
        chk("R9 bits kept", {2'b0, stat_out}, 8'h2B);
        stat_op(1'b1, 1'b1, 6'h3F);
        chk("R10 clr beats wr", {2'b0, stat_out}, 8'h00);
        @(negedge clk);
        stat_clr = 1'b1; op_valid = 1'b1; op_mode = 1'b1; opnd_a = QNAN; opnd_b = F5;
        @(posedge clk); #1;
        stat_clr = 1'b0; op_valid = 1'b0;
        chk("R10 clr with invalid", {2'b0, stat_out}, 8'h01);
        stat_op(1'b1, 1'b0, 6'h00);
    endtask

    task automatic t_hold();
        cmp(1'b0, F5, F1000);
        chk("R11 updated", flags_out, 8'h01);
        @(negedge clk);
        opnd_a = F1000; opnd_b = QNAN; op_mode = 1'b1;
        @(posedge clk); #1;
        chk("R11 hold flags", flags_out, 8'h01);
        chk("R11 hold stat", {2'b0, stat_out}, 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_greater();
        t_less();
        t_equal();
        t_order();
        t_unord_mode();
        t_clear();
        t_ord_mode();
        t_write();
        t_hold();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule